// File: doc/BRIEF.md
# Dual-Bank Core Memory with Background Loader

This block is the local register and program memory of one processor core. It holds two equal banks of words. Exactly one bank is active: the core's instruction fetch port, its operand read port and its result write port all address that bank. In a single clock the active bank serves one fetch, one operand read and one write. Reads are registered and return data one cycle after they are issued. When a read and a write hit the same word in the same cycle, the read returns the old contents.

While the core runs from the active bank, a loader copies a block of consecutive words from a shared main memory into the other bank. A load command names the target bank and a word start address. The core is never stalled by the copy. The main-memory port carries an arbiter. The core's own main-memory reads and writes always win over the loader. The loader moves on to the next word only when it has been granted, so a denied word is requested again.

A switch command moves execution to the other bank. The fetch issued in the cycle after the command already reads the new bank. If the requested bank is still being filled, fetch stalls until the fill completes, and the switch then takes effect in the same cycle that busy drops.

Top module: `dbm_core_mem`

## Requirements
- R1: After reset the active bank is 0, and load_busy, load_err and fetch_stall are all 0.
- R2: A fetch, an operand read and a write to distinct addresses of the active bank may all occur in one cycle. Each read returns the word stored at its address on the rising edge after it is issued.
- R3: An accepted load copies words base+i of main memory into word i of the target bank, for i = 0 to DEPTH-1.
- R4: While a load is running, the core's fetch, operand read and write to the active bank keep working, and fetch_stall stays 0 unless a switch to the loading bank is pending.
- R5: When core_req is high, the main-memory port carries the core's address and write flag, and core_gnt follows mem_gnt. A granted core read raises core_rvalid one cycle later, with core_rdata equal to the memory's returned word.
- R6: The loader's word index and address advance only on cycles in which the loader is granted. A word that is denied, whether by mem_gnt low or by a core request, is requested again, and the copied contents stay complete and in order.
- R7: A load command whose target equals the active bank is refused. load_err is 1 on the following cycle and no load starts.
- R8: A load command issued while load_busy is 1 is refused with load_err. The running load keeps its original base address.
- R9: With an uninterrupted grant, load_busy is 1 for exactly DEPTH+1 cycles after the accepting edge. It stays 1 until the edge after the last word is written.
- R10: A switch to a bank that is not being loaded sets active_bank on the next edge with no stall. The fetch issued in the following cycle reads the new bank.
- R11: A switch to the bank being loaded raises fetch_stall on the next edge and holds it while load_busy is 1. Both fetch_stall and load_busy drop on the same edge, and active_bank takes the new value on that edge.
- R12: A load whose base exceeds 2^MAIN_AW - DEPTH is refused with load_err, so a load never wraps past the top of main memory. Base 2^MAIN_AW - DEPTH is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Instruction fetch request |
| fetch_addr | input | AW | Fetch word address (program counter) |
| fetch_data | output | DW | Fetched word, one cycle after the request |
| fetch_stall | output | 1 | Fetch is held for a pending switch |
| opr_en | input | 1 | Operand read request |
| opr_addr | input | AW | Operand word address |
| opr_data | output | DW | Operand word, one cycle after the request |
| wr_en | input | 1 | Result write enable |
| wr_addr | input | AW | Result word address |
| wr_data | input | DW | Result word |
| load_cmd | input | 1 | Start a background bank load |
| load_bank | input | 1 | Target bank of the load |
| load_base | input | MAIN_AW | Main-memory word address of the first word |
| switch_cmd | input | 1 | Switch the execution bank |
| switch_bank | input | 1 | Bank to execute from |
| active_bank | output | 1 | Current execution bank |
| load_busy | output | 1 | A load is in progress |
| load_err | output | 1 | The previous cycle's load command was refused |
| core_req | input | 1 | Core main-memory access request |
| core_we | input | 1 | Core access is a write |
| core_addr | input | MAIN_AW | Core main-memory word address |
| core_wdata | input | DW | Core write data |
| core_gnt | output | 1 | Core access granted this cycle |
| core_rvalid | output | 1 | Core read data valid |
| core_rdata | output | DW | Core read data |
| mem_req | output | 1 | Main-memory request |
| mem_we | output | 1 | Main-memory write |
| mem_addr | output | MAIN_AW | Main-memory word address |
| mem_wdata | output | DW | Main-memory write data |
| mem_gnt | input | 1 | Main memory accepts the request this cycle |
| mem_rdata | input | DW | Read data, one cycle after a granted read |

## Verification
The bench builds the block with AW=3, which gives banks of 8 words, and MAIN_AW=6, which gives a main memory of 64 words. Each load therefore lasts about ten cycles. This makes the exact busy length, a grant pattern that denies the loader several times mid-load, a switch that stalls until completion, and a refusal while busy all reachable in a short run. The small main memory also puts the top boundary within reach: base 56 must be accepted and must copy the last word, and base 57 must be refused.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int unsigned NUM_BANKS = 2;
  typedef logic bank_t;
endpackage

// File: rtl/dbm_bank.sv
module dbm_bank #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re_a,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic          re_b,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] store [WORDS];

  // read-first: both read ports see the contents before this cycle's write
  always_ff @(posedge clk) begin
    if (we)   store[waddr] <= wdata;
    if (re_a) rdata_a <= store[raddr_a];
    if (re_b) rdata_b <= store[raddr_b];
  end
endmodule

// File: rtl/dbm_arb.sv
module dbm_arb #(
  parameter int unsigned DW      = 32,
  parameter int unsigned MAIN_AW = 16
) (
  input  logic               core_req,
  input  logic               core_we,
  input  logic [MAIN_AW-1:0] core_addr,
  input  logic [DW-1:0]      core_wdata,
  input  logic               ld_req,
  input  logic [MAIN_AW-1:0] ld_addr,
  input  logic               mem_gnt,
  output logic               mem_req,
  output logic               mem_we,
  output logic [MAIN_AW-1:0] mem_addr,
  output logic [DW-1:0]      mem_wdata,
  output logic               core_gnt,
  output logic               ld_gnt
);
  // strict priority: the core always owns the port when it asks
  always_comb begin
    mem_req   = core_req | ld_req;
    mem_we    = core_req & core_we;
    mem_addr  = core_req ? core_addr : ld_addr;
    mem_wdata = core_wdata;
    core_gnt  = core_req & mem_gnt;
    ld_gnt    = ld_req & ~core_req & mem_gnt;
  end
endmodule

// File: rtl/dbm_loader.sv
module dbm_loader
  import dbm_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 9,
  parameter int unsigned MAIN_AW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd,
  input  bank_t              cmd_bank,
  input  logic [MAIN_AW-1:0] cmd_base,
  input  bank_t              active_bank,
  input  logic               ld_gnt,
  input  logic [DW-1:0]      mem_rdata,
  output logic               busy,
  output bank_t              tgt_bank,
  output logic               accept,
  output logic               done,
  output logic               err,
  output logic               ld_req,
  output logic [MAIN_AW-1:0] ld_addr,
  output logic               wr_en,
  output logic [AW-1:0]      wr_idx,
  output logic [DW-1:0]      wr_data
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [MAIN_AW:0] BASE_MAX = (MAIN_AW+1)'((1 << MAIN_AW) - DEPTH);

  logic               busy_q, err_q, pend_q;
  bank_t              tgt_q;
  logic [AW:0]        issue_q;
  logic [AW-1:0]      idx_q;
  logic [MAIN_AW-1:0] addr_q;
  logic               range_ok;

  always_comb begin
    range_ok = {1'b0, cmd_base} <= BASE_MAX;
    accept   = cmd & ~busy_q & (cmd_bank != active_bank) & range_ok;
    ld_req   = busy_q & ~issue_q[AW];
    done     = pend_q & (&idx_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      pend_q  <= 1'b0;
      tgt_q   <= 1'b0;
      issue_q <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
    end else begin
      err_q  <= cmd & ~accept;
      pend_q <= ld_gnt;
      if (ld_gnt) begin
        idx_q   <= issue_q[AW-1:0];
        issue_q <= issue_q + 1'b1;
        addr_q  <= addr_q + 1'b1;
      end
      if (accept) begin
        busy_q  <= 1'b1;
        tgt_q   <= cmd_bank;
        addr_q  <= cmd_base;
        issue_q <= '0;
      end else if (done) begin
        busy_q  <= 1'b0;
      end
    end
  end

  assign busy     = busy_q;
  assign tgt_bank = tgt_q;
  assign err      = err_q;
  assign ld_addr  = addr_q;
  assign wr_en    = pend_q;
  assign wr_idx   = idx_q;
  assign wr_data  = mem_rdata;
endmodule

// File: rtl/dbm_core_mem.sv
module dbm_core_mem
  import dbm_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 9,
  parameter int unsigned MAIN_AW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_en,
  input  logic [AW-1:0]      fetch_addr,
  output logic [DW-1:0]      fetch_data,
  output logic               fetch_stall,
  input  logic               opr_en,
  input  logic [AW-1:0]      opr_addr,
  output logic [DW-1:0]      opr_data,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               load_cmd,
  input  logic               load_bank,
  input  logic [MAIN_AW-1:0] load_base,
  input  logic               switch_cmd,
  input  logic               switch_bank,
  output logic               active_bank,
  output logic               load_busy,
  output logic               load_err,
  input  logic               core_req,
  input  logic               core_we,
  input  logic [MAIN_AW-1:0] core_addr,
  input  logic [DW-1:0]      core_wdata,
  output logic               core_gnt,
  output logic               core_rvalid,
  output logic [DW-1:0]      core_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [MAIN_AW-1:0] mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic               mem_gnt,
  input  logic [DW-1:0]      mem_rdata
);
  bank_t              active_q, fsel_q, osel_q;
  logic               pend_q, rvalid_q;
  logic               ld_busy, ld_accept, ld_done, ld_err, ld_req, ld_gnt;
  logic               ld_wr_en;
  bank_t              ld_tgt, ld_tgt_eff;
  logic [AW-1:0]      ld_wr_idx;
  logic [DW-1:0]      ld_wr_data;
  logic [MAIN_AW-1:0] ld_addr;
  logic               loading_eff, fetch_re;
  logic [DW-1:0]      rd_f [NUM_BANKS];
  logic [DW-1:0]      rd_o [NUM_BANKS];

  dbm_loader #(.DW(DW), .AW(AW), .MAIN_AW(MAIN_AW)) u_loader (
    .clk(clk), .rst(rst), .cmd(load_cmd), .cmd_bank(load_bank),
    .cmd_base(load_base), .active_bank(active_q), .ld_gnt(ld_gnt),
    .mem_rdata(mem_rdata), .busy(ld_busy), .tgt_bank(ld_tgt),
    .accept(ld_accept), .done(ld_done), .err(ld_err), .ld_req(ld_req),
    .ld_addr(ld_addr), .wr_en(ld_wr_en), .wr_idx(ld_wr_idx),
    .wr_data(ld_wr_data)
  );

  dbm_arb #(.DW(DW), .MAIN_AW(MAIN_AW)) u_arb (
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
    .core_wdata(core_wdata), .ld_req(ld_req), .ld_addr(ld_addr),
    .mem_gnt(mem_gnt), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .core_gnt(core_gnt),
    .ld_gnt(ld_gnt)
  );

  // a load is "live" for switch purposes unless it finishes this cycle
  assign loading_eff = (ld_busy & ~ld_done) | ld_accept;
  assign ld_tgt_eff  = ld_busy ? ld_tgt : load_bank;
  assign fetch_re    = fetch_en & ~pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      fsel_q   <= 1'b0;
      osel_q   <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= core_gnt & ~core_we;
      if (fetch_re) fsel_q <= active_q;
      if (opr_en)   osel_q <= active_q;
      if (ld_done && pend_q) begin
        active_q <= ld_tgt;
        pend_q   <= 1'b0;
      end
      if (switch_cmd) begin
        if (loading_eff && switch_bank == ld_tgt_eff) begin
          pend_q <= 1'b1;
        end else begin
          active_q <= switch_bank;
          pend_q   <= 1'b0;
        end
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic          is_act, b_we;
    logic [AW-1:0] b_waddr;
    logic [DW-1:0] b_wdata;

    always_comb begin
      is_act  = (active_q == 1'(b));
      b_we    = is_act ? wr_en : (ld_wr_en && ld_tgt == 1'(b));
      b_waddr = is_act ? wr_addr : ld_wr_idx;
      b_wdata = is_act ? wr_data : ld_wr_data;
    end

    dbm_bank #(.DW(DW), .AW(AW)) u_bank (
      .clk(clk), .we(b_we), .waddr(b_waddr), .wdata(b_wdata),
      .re_a(fetch_re & is_act), .raddr_a(fetch_addr), .rdata_a(rd_f[b]),
      .re_b(opr_en & is_act), .raddr_b(opr_addr), .rdata_b(rd_o[b])
    );
  end

  assign fetch_data  = rd_f[fsel_q];
  assign opr_data    = rd_o[osel_q];
  assign fetch_stall = pend_q;
  assign active_bank = active_q;
  assign load_busy   = ld_busy;
  assign load_err    = ld_err;
  assign core_rvalid = rvalid_q;
  assign core_rdata  = mem_rdata;
endmodule

// File: rtl/dbm_core_mem_chk.sv
module dbm_core_mem_chk #(
  parameter int unsigned MAIN_AW = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               core_req,
  input logic [MAIN_AW-1:0] core_addr,
  input logic               core_gnt,
  input logic               mem_req,
  input logic               mem_gnt,
  input logic [MAIN_AW-1:0] mem_addr,
  input logic               load_cmd,
  input logic               load_bank,
  input logic               load_busy,
  input logic               load_err,
  input logic               switch_cmd,
  input logic               switch_bank,
  input logic               active_bank,
  input logic               fetch_stall
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (active_bank == 1'b0) && !load_busy && !fetch_stall);

  a_r5_core_wins: assert property (@(posedge clk) disable iff (rst)
    core_req && mem_gnt |-> core_gnt && (mem_addr == core_addr));

  a_r6_loader_only_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req && !core_req |-> load_busy);

  a_r7_active_target_refused: assert property (@(posedge clk) disable iff (rst)
    load_cmd && (load_bank == active_bank) |=> load_err);

  a_r8_busy_refused: assert property (@(posedge clk) disable iff (rst)
    load_cmd && load_busy |=> load_err);

  a_r10_idle_switch: assert property (@(posedge clk) disable iff (rst)
    switch_cmd && !load_busy && !load_cmd |=>
      (active_bank == $past(switch_bank)) && !fetch_stall);

  a_r11_stall_needs_busy: assert property (@(posedge clk) disable iff (rst)
    fetch_stall |-> load_busy);
endmodule

bind dbm_core_mem dbm_core_mem_chk #(.MAIN_AW(MAIN_AW)) u_chk (
  .clk(clk), .rst(rst), .core_req(core_req), .core_addr(core_addr),
  .core_gnt(core_gnt), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .load_cmd(load_cmd), .load_bank(load_bank),
  .load_busy(load_busy), .load_err(load_err), .switch_cmd(switch_cmd),
  .switch_bank(switch_bank), .active_bank(active_bank),
  .fetch_stall(fetch_stall)
);

// File: tb/tb_dbm_core_mem.sv
module tb_dbm_core_mem;
  localparam int unsigned DW = 32, AW = 3, MAIN_AW = 6;
  localparam int unsigned DEPTH = 1 << AW, MWORDS = 1 << MAIN_AW;

  // {address, data}: write these into bank 0, read back through both ports
  localparam logic [34:0] VEC [8] = '{
    {3'd5, 32'hDEAD_0005}, {3'd2, 32'h1357_9BDF}, {3'd7, 32'hFFFF_0000},
    {3'd0, 32'h0000_FFFF}, {3'd3, 32'hA5A5_5A5A}, {3'd6, 32'h8000_0001},
    {3'd1, 32'h7654_3210}, {3'd4, 32'h0F0F_F0F0}};

  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic fetch_en = 0, opr_en = 0, wr_en = 0;
  logic [AW-1:0] fetch_addr = 0, opr_addr = 0, wr_addr = 0;
  logic [DW-1:0] wr_data = 0, fetch_data, opr_data;
  logic fetch_stall, active_bank, load_busy, load_err;
  logic load_cmd = 0, load_bank = 0, switch_cmd = 0, switch_bank = 0;
  logic [MAIN_AW-1:0] load_base = 0, core_addr = 0, mem_addr;
  logic core_req = 0, core_we = 0, core_gnt, core_rvalid;
  logic [DW-1:0] core_wdata = 0, core_rdata, mem_wdata, mem_rdata = 0;
  logic mem_req, mem_we, mem_gnt, gnt_allow = 1;

  logic [DW-1:0] mm [MWORDS];
  int nchk = 0, nfail = 0;

  dbm_core_mem #(.DW(DW), .AW(AW), .MAIN_AW(MAIN_AW)) dut (.*);

  assign mem_gnt = mem_req & gnt_allow;
  always @(posedge clk)
    if (mem_req && mem_gnt) begin
      if (mem_we) mm[mem_addr] <= mem_wdata;
      else        mem_rdata <= mm[mem_addr];
    end

  function automatic logic [DW-1:0] pat(int i);
    return 32'h5A00_0000 | (32'(i) << 8) | (32'(i) ^ 32'h3C);
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fetch_chk(string tag, logic [AW-1:0] a, logic [DW-1:0] exp);
    fetch_en = 1; fetch_addr = a;
    @(negedge clk);
    fetch_en = 0;
    chk(tag, fetch_data, exp);
  endtask

  task automatic start_load(logic b, logic [MAIN_AW-1:0] base);
    load_cmd = 1; load_bank = b; load_base = base;
    @(negedge clk);
    load_cmd = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 100 && load_busy; k++) @(negedge clk);
  endtask

  task automatic do_switch(logic b);
    switch_cmd = 1; switch_bank = b;
    @(negedge clk);
    switch_cmd = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cnt;
    for (int i = 0; i < MWORDS; i++) mm[i] = pat(i);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 active", 32'(active_bank), 0);
    chk("R1 busy", 32'(load_busy), 0);
    chk("R1 stall", 32'(fetch_stall), 0);
    chk("R1 err", 32'(load_err), 0);

    // R2 table walk: write, fetch and operand read in the same cycle
    for (int i = 0; i < 10; i++) begin
      wr_en = (i < 8);
      if (i < 8) begin wr_addr = VEC[i][34:32]; wr_data = VEC[i][31:0]; end
      fetch_en = (i >= 1); opr_en = (i >= 2);
      if (i >= 1) fetch_addr = VEC[i-1][34:32];
      if (i >= 2) opr_addr = VEC[i-2][34:32];
      @(negedge clk);
      wr_en = 0; fetch_en = 0; opr_en = 0;
      if (i >= 1) chk("R2 fetch", fetch_data, VEC[i-1][31:0]);
      if (i >= 2) chk("R2 operand", opr_data, VEC[i-2][31:0]);
    end

    // R9 busy length, R4 core keeps running during the load
    start_load(1'b1, 6'd5);
    cnt = 0;
    for (int k = 0; k < 50 && load_busy; k++) begin
      cnt++;
      chk("R4 no stall", 32'(fetch_stall), 0);
      if (k == 0) begin wr_en = 1; wr_addr = 3'd5; wr_data = 32'h1234_ABCD; end
      if (k == 1) begin
        wr_en = 0; fetch_en = 1; fetch_addr = 3'd5; opr_en = 1; opr_addr = 3'd2;
      end
      if (k == 2) begin
        fetch_en = 0; opr_en = 0;
        chk("R4 fetch during load", fetch_data, 32'h1234_ABCD);
        chk("R4 operand during load", opr_data, 32'h1357_9BDF);
      end
      @(negedge clk);
    end
    chk("R9 busy cycles", 32'(cnt), 32'(DEPTH + 1));

    // R10 immediate switch to idle bank, R3 copied contents
    switch_cmd = 1; switch_bank = 1;
    @(negedge clk);
    switch_cmd = 0;
    chk("R10 active", 32'(active_bank), 1);
    chk("R10 stall", 32'(fetch_stall), 0);
    for (int j = 0; j < DEPTH; j++) fetch_chk("R3 copy", 3'(j), pat(5 + j));

    // R5 core priority, R6 retry under denied grants
    start_load(1'b0, 6'd20);
    for (int k = 0; k < 100 && load_busy; k++) begin
      gnt_allow = (k % 3 != 1);
      if (k == 2) begin
        core_req = 1; core_we = 0; core_addr = 6'd40;
        #1;
        chk("R5 core grant", 32'(core_gnt), 1);
        chk("R5 port address", 32'(mem_addr), 40);
      end
      if (k == 3) begin
        core_req = 0;
        chk("R5 rvalid", 32'(core_rvalid), 1);
        chk("R5 rdata", core_rdata, pat(40));
      end
      @(negedge clk);
    end
    gnt_allow = 1;
    do_switch(1'b0);
    for (int j = 0; j < DEPTH; j++) fetch_chk("R6 copy after retries", 3'(j), pat(20 + j));

    // R7 load to the active bank is refused
    start_load(1'b0, 6'd0);
    chk("R7 err", 32'(load_err), 1);
    chk("R7 no busy", 32'(load_busy), 0);
    fetch_chk("R7 bank untouched", 3'd3, pat(23));

    // R8 refusal while busy, R11 stalled switch
    start_load(1'b1, 6'd30);
    start_load(1'b1, 6'd40);
    chk("R8 err", 32'(load_err), 1);
    chk("R8 busy kept", 32'(load_busy), 1);
    do_switch(1'b1);
    for (int k = 0; k < 50 && load_busy; k++) begin
      chk("R11 stall held", 32'(fetch_stall), 1);
      chk("R11 still bank0", 32'(active_bank), 0);
      @(negedge clk);
    end
    chk("R11 stall cleared", 32'(fetch_stall), 0);
    chk("R11 switched", 32'(active_bank), 1);
    for (int j = 0; j < DEPTH; j++) fetch_chk("R8 original base", 3'(j), pat(30 + j));

    // R12 top-of-memory bound
    start_load(1'b0, 6'(MWORDS - DEPTH + 1));
    chk("R12 err above top", 32'(load_err), 1);
    chk("R12 not busy", 32'(load_busy), 0);
    start_load(1'b0, 6'(MWORDS - DEPTH));
    chk("R12 accepted at top", 32'(load_busy), 1);
    chk("R12 no err", 32'(load_err), 0);
    wait_idle();
    do_switch(1'b0);
    fetch_chk("R12 last word", 3'(DEPTH - 1), pat(MWORDS - 1));
    fetch_chk("R12 first word", 3'd0, pat(MWORDS - DEPTH));

    finish_run();
  end
endmodule